// File: doc/BRIEF.md
# Stack-to-Memory Byte Port

This block connects the evaluation stack of a 16-bit stack machine to a byte-addressed data memory that it holds internally. The instruction sequencer issues one command at a time: a word or byte load, a word or byte store, or a fetch of the inline literal that follows a push instruction. The sequencer takes the operands from the stack and hands them over with the command. For a load, the address is the top of stack. For a store, the address is the entry beneath the top of stack and the data is the top itself. Loaded values come back as 16-bit stack values.

Every access is made of byte-wide memory cycles, with the low byte at the lower address. A word access uses two consecutive byte cycles. The address of its second byte wraps from the top of the memory back to address zero. A one-clock `done` pulse marks completion, and `rd_data` holds the result until the next load completes. The address width is the parameter `ADDR_W`. The full machine uses 16, which gives 65536 bytes. The default is 10, which keeps the elaborated array small.

Top module: `stack_mem_port`

## Requirements
- R1: After reset `cmd_ready` is 1, `done` is 0, `rd_data` is 0, and every memory byte reads back as 0.
- R2: Word store (`cmd_op` = 2) writes `cmd_wdata[7:0]` to byte `cmd_addr` and `cmd_wdata[15:8]` to byte `cmd_addr`+1.
- R3: Word load (`cmd_op` = 0) returns the byte at `cmd_addr`+1 in `rd_data[15:8]` and the byte at `cmd_addr` in `rd_data[7:0]`.
- R4: Byte load (`cmd_op` = 1) returns the byte at `cmd_addr` with `rd_data[15:8]` equal to 0.
- R5: Byte store (`cmd_op` = 3) writes only `cmd_wdata[7:0]` to byte `cmd_addr`. The upper data bits are dropped and neighbouring bytes keep their values.
- R6: For the literal fetches, `cmd_addr` is the address of the push opcode. The byte literal (`cmd_op` = 4) returns the zero-extended byte at `cmd_addr`+1. The word literal (`cmd_op` = 5) returns the byte at `cmd_addr`+2 as the high byte and the byte at `cmd_addr`+1 as the low byte.
- R7: All address arithmetic wraps modulo 2^`ADDR_W`. A word access at the top address uses address 0 for its high byte.
- R8: `done` is high for exactly one clock. For a single-byte command it is high in the second cycle after the accepting edge. For a two-byte command it is high in the third cycle after that edge.
- R9: A command is accepted on a clock edge with `cmd_valid` and `cmd_ready` both high. `cmd_ready` is low from acceptance until `done` rises, and commands offered while it is low are ignored.
- R10: Stores and the unused codes 6 and 7 leave `rd_data` unchanged. The unused codes touch no memory and complete in the single-byte time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears memory |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 3 | Command code (0 word load, 1 byte load, 2 word store, 3 byte store, 4 byte literal, 5 word literal) |
| cmd_addr | input | ADDR_W | Byte address, or opcode address for literals |
| cmd_wdata | input | 16 | Store data (top of stack) |
| cmd_ready | output | 1 | Idle, able to accept a command |
| rd_data | output | 16 | Last loaded value |
| done | output | 1 | One-clock completion pulse |

## Verification
The bench builds the block with `ADDR_W` = 8. This makes the memory 256 bytes, so the top address and its wrap to zero are exercised directly by word loads, word stores and literal fetches. A mid-run reset is checked by reading back locations that were written earlier. With the small array, a reference byte model in the bench can follow every store exactly.

// File: rtl/stack_mem_port.sv
module stack_mem_port #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [15:0]       cmd_wdata,
  output logic              cmd_ready,
  output logic [15:0]       rd_data,
  output logic              done
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [2:0] OP_LDW = 3'd0, OP_LDB = 3'd1, OP_STW = 3'd2,
                         OP_STB = 3'd3, OP_LITB = 3'd4, OP_LITW = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI} st_t;

  logic [7:0]        mem [DEPTH];
  st_t               st;
  logic [2:0]        op_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [15:0]       wd_q, rd_q;
  logic              done_q;

  wire is_wr   = (op_q == OP_STW) || (op_q == OP_STB);
  wire is_rd   = (op_q == OP_LDW) || (op_q == OP_LDB) ||
                 (op_q == OP_LITB) || (op_q == OP_LITW);
  wire is_wide = (op_q == OP_LDW) || (op_q == OP_STW) || (op_q == OP_LITW);
  wire new_lit = (cmd_op == OP_LITB) || (cmd_op == OP_LITW);

  assign cmd_ready = (st == S_IDLE);
  assign rd_data   = rd_q;
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      st     <= S_IDLE;
      op_q   <= '0;
      ptr_q  <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          op_q  <= cmd_op;
          ptr_q <= new_lit ? cmd_addr + 1'b1 : cmd_addr;
          wd_q  <= cmd_wdata;
          st    <= S_LO;
        end
        S_LO: begin
          if (is_wr) mem[ptr_q] <= wd_q[7:0];
          if (is_rd) rd_q <= {8'h00, mem[ptr_q]};
          if (is_wide) begin
            ptr_q <= ptr_q + 1'b1;
            st    <= S_HI;
          end else begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end
        end
        S_HI: begin
          if (is_wr) mem[ptr_q] <= wd_q[15:8];
          if (is_rd) rd_q[15:8] <= mem[ptr_q];
          st     <= S_IDLE;
          done_q <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stack_mem_port_chk.sv
module stack_mem_port_chk (
  input logic        clk,
  input logic        rst,
  input logic        cmd_valid,
  input logic [2:0]  cmd_op,
  input logic        cmd_ready,
  input logic [15:0] rd_data,
  input logic        done
);
  logic [2:0] last_op;
  wire acc      = cmd_valid && cmd_ready;
  wire acc_wide = acc && (cmd_op == 3'd0 || cmd_op == 3'd2 || cmd_op == 3'd5);
  wire acc_narr = acc && !(cmd_op == 3'd0 || cmd_op == 3'd2 || cmd_op == 3'd5);

  always_ff @(posedge clk) begin
    if (rst) last_op <= '0;
    else if (acc) last_op <= cmd_op;
  end

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_byte_latency_r8: assert property (@(posedge clk) disable iff (rst)
    acc_narr |=> !done ##1 done);
  p_word_latency_r8: assert property (@(posedge clk) disable iff (rst)
    acc_wide |=> !done ##1 !done ##1 done);
  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (rst)
    acc |=> !cmd_ready);
  p_ready_at_done_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> cmd_ready);
  p_zero_extend_r4: assert property (@(posedge clk) disable iff (rst)
    (done && (last_op == 3'd1 || last_op == 3'd4)) |-> rd_data[15:8] == 8'h00);
  p_keep_result_r10: assert property (@(posedge clk) disable iff (rst)
    (done && (last_op == 3'd2 || last_op == 3'd3 || last_op[2:1] == 2'b11))
      |-> $stable(rd_data));
endmodule

bind stack_mem_port stack_mem_port_chk u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_ready(cmd_ready), .rd_data(rd_data), .done(done)
);

// File: tb/tb_stack_mem_port.sv
module tb_stack_mem_port;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int TOP = DEPTH - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic cmd_ready, done;
  logic [15:0] rd_data;

  stack_mem_port #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
    .rd_data(rd_data), .done(done)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  logic [7:0] model [DEPTH];
  logic [15:0] last_rd = '0;
  logic [15:0] exp_q[$];
  int lat_q[$], acc_q[$];
  string tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expectation per done pulse
  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_q.size() == 0) chk("R8 unexpected done", 1, 0);
      else begin
        automatic string t = tag_q.pop_front();
        chk(t, rd_data, exp_q.pop_front());
        chk({t, " R8 latency"}, cyc - acc_q.pop_front(), lat_q.pop_front());
      end
    end
  end

  function automatic logic [AW-1:0] a(input int x);
    return AW'(x);
  endfunction

  // driver: computes expectation from the byte model and issues the command
  task automatic issue(input logic [2:0] op, input int addr, input logic [15:0] wd, input string tag);
    logic [15:0] e;
    int lat;
    while (!cmd_ready) @(negedge clk);
    e = last_rd; lat = 1;
    case (op)
      3'd0: begin e = {model[a(addr+1)], model[a(addr)]}; lat = 2; end
      3'd1: e = {8'h00, model[a(addr)]};
      3'd2: begin model[a(addr)] = wd[7:0]; model[a(addr+1)] = wd[15:8]; lat = 2; end
      3'd3: model[a(addr)] = wd[7:0];
      3'd4: e = {8'h00, model[a(addr+1)]};
      3'd5: begin e = {model[a(addr+2)], model[a(addr+1)]}; lat = 2; end
      default: ;
    endcase
    last_rd = e;
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a(addr); cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
    exp_q.push_back(e); lat_q.push_back(lat); acc_q.push_back(cyc); tag_q.push_back(tag);
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || !cmd_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    last_rd = '0;
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 ready after reset", cmd_ready, 1);
    chk("R1 done after reset", done, 0);
    chk("R1 rd_data after reset", rd_data, 0);
    issue(3'd0, 17, 0, "R1 cleared word");
    issue(3'd1, TOP, 0, "R1 cleared byte");

    issue(3'd2, 16, 16'hBEEF, "R2 word store");
    issue(3'd1, 16, 0, "R2 low byte at address");
    issue(3'd1, 17, 0, "R2 high byte at address+1");
    issue(3'd0, 16, 0, "R3 word load");
    issue(3'd0, 17, 0, "R3 word load unaligned");
    issue(3'd2, 40, 16'h80F1, "R2 word store 2");
    issue(3'd1, 41, 0, "R4 byte load upper zero");
    issue(3'd3, 50, 16'h1234, "R5 byte store");
    issue(3'd0, 50, 0, "R5 neighbour kept");
    issue(3'd2, 60, 16'hAAAA, "R5 setup");
    issue(3'd3, 61, 16'hFF55, "R5 upper bits dropped");
    issue(3'd0, 60, 0, "R5 readback");

    issue(3'd2, 100, 16'hC3A5, "R6 setup");
    issue(3'd4, 99, 0, "R6 byte literal");
    issue(3'd5, 99, 0, "R6 word literal");

    issue(3'd2, TOP, 16'h7E81, "R7 store at top");
    issue(3'd1, 0, 0, "R7 high byte wrapped to 0");
    issue(3'd0, TOP, 0, "R7 load at top");
    issue(3'd4, TOP, 0, "R6 R7 byte literal wraps");
    issue(3'd5, TOP - 1, 0, "R6 R7 word literal crosses top");
    issue(3'd5, TOP, 0, "R6 R7 word literal wraps");

    issue(3'd0, 40, 0, "R10 setup load");
    issue(3'd2, 70, 16'h0102, "R10 store keeps rd_data");
    issue(3'd3, 71, 16'h0304, "R10 byte store keeps rd_data");
    issue(3'd6, 72, 16'hFFFF, "R10 code 6");
    issue(3'd7, 73, 16'hFFFF, "R10 code 7");
    issue(3'd0, 72, 0, "R10 unused codes wrote nothing");

    // R9: command offered while busy is ignored
    drain();
    issue(3'd2, 80, 16'h1111, "R9 busy store");
    chk("R9 ready low while busy", cmd_ready, 0);
    cmd_valid = 1'b1; cmd_op = 3'd3; cmd_addr = a(90); cmd_wdata = 16'h00EE;
    @(negedge clk);
    cmd_valid = 1'b0;
    drain();
    issue(3'd1, 90, 0, "R9 ignored store left byte at 0");

    // patterned traffic against the model
    for (int i = 0; i < 120; i++) begin
      automatic int ad = (i * 37 + 11) % DEPTH;
      automatic logic [15:0] d = 16'(i * 16'h2F1B + 16'h0137);
      case (i % 6)
        0: issue(3'd2, ad, d, "R2 pattern store");
        1: issue(3'd0, ad, 0, "R3 pattern load");
        2: issue(3'd3, ad, d, "R5 pattern byte store");
        3: issue(3'd1, ad, 0, "R4 pattern byte load");
        4: issue(3'd4, ad, 0, "R6 pattern byte literal");
        default: issue(3'd5, ad, 0, "R6 pattern word literal");
      endcase
    end
    drain();

    // R1: reset clears previously written memory
    do_reset();
    chk("R1 rd_data after second reset", rd_data, 0);
    issue(3'd0, 16, 0, "R1 memory cleared by reset");
    issue(3'd0, TOP, 0, "R1 top cleared by reset");
    drain();

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule